// File: doc/BRIEF.md
# Flit Link Receive Buffer

This block terminates one direction of a point-to-point flit link, either between two routers or between a router and the interface of its attached core. The sending side drives a 34-bit flit and a put strobe. The receiving side answers with a ready-to-receive flag. Each flit is handed over in a four-phase level handshake. The flag is high while a slot is free. The sender raises put together with the data. The receiver takes the flit and lowers its flag. The sender withdraws put. The receiver raises the flag again only when a slot is still free.

Accepted flits go into a small circular store. The store keeps a read pointer and a write pointer, each with one extra wrap bit. The router side sees the oldest stored flit through a valid/flit pair and removes it with a one-cycle get pulse. A get and a link write may happen in the same cycle.

Top module: `rtr_flit_rx`

## Requirements
- R1: A synchronous active-high reset empties the store. After reset, rdy_o is 1 and valid_o is 0.
- R2: A flit is captured at the first rising clock edge where put_i and rdy_o are both 1. Exactly one entry is written. From the cycle after that edge, rdy_o is 0.
- R3: While put_i stays 1 after a capture, rdy_o stays 0 and nothing more is written, whatever value flit_i holds.
- R4: rdy_o rises only at an edge where put_i was 0. After the sender drops put_i, rdy_o is 1 one cycle later if a slot is free at that edge. A slot counts as free if the store is not full, or if a get pops an entry at that edge.
- R5: With all DEPTH (default 4) entries occupied, rdy_o stays 0. It rises one cycle after the edge at which a get frees a slot, provided put_i is 0.
- R6: valid_o is 1 exactly when the store holds a flit. flit_o shows the oldest stored flit. Flits leave in the order they arrived.
- R7: A get pulse while valid_o is 0 has no effect: valid_o stays 0 and no later flit is lost.
- R8: A get in the same cycle as a write leaves the occupancy unchanged. The oldest flit is removed and the new one is appended.
- R9: Exactly DEPTH flits can be held before the link stalls, and each of them is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| put_i | input | 1 | Sender's put strobe |
| flit_i | input | 34 | Flit presented by the sender |
| rdy_o | output | 1 | Ready-to-receive flag to the sender |
| get_i | input | 1 | Router-side pop pulse |
| valid_o | output | 1 | A flit is available on flit_o |
| flit_o | output | 34 | Oldest stored flit |

## Verification
Two things can land on the same edge: a link write, and a router-side pop that either frees a slot or drains the head. The stimulus table drives put and get together in the cycle a flit is captured. It then counts the pops needed to empty the store, which shows the occupancy did not change. It also drives a get in the cycle the sender withdraws put. The flag must then rise at once rather than a cycle later. With the store full, one pop must reopen the link. The four survivors must then come out in order, with no duplicate from a put that was held too long.

// File: rtl/rtr_flit_rx_pkg.sv
package rtr_flit_rx_pkg;

  // Handshake phases of the receiving side of the link.
  typedef enum logic [1:0] {
    PH_OPEN  = 2'd0,  // flag high, waiting for put
    PH_HOLD  = 2'd1,  // flit taken, waiting for put to drop
    PH_STALL = 2'd2   // put dropped but no slot free
  } link_phase_e;

  localparam int unsigned FLIT_W_DEF = 34;
  localparam int unsigned DEPTH_DEF  = 4;

endpackage

// File: rtl/rtr_flit_ring.sv
module rtr_flit_ring #(
  parameter int unsigned FLIT_W = 34,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FLIT_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [FLIT_W-1:0] head,
  output logic              full,
  output logic              empty,
  output logic [PTR_W-1:0]  occ
);

  // Pointer arithmetic kept in functions so the wrap rule sits in one place.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] fill_level(input logic [PTR_W-1:0] w,
                                                  input logic [PTR_W-1:0] r);
    return w - r;
  endfunction

  logic [PTR_W-1:0]  wp, rp;
  logic [FLIT_W-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en) wp <= ptr_step(wp);
      if (rd_en) rp <= ptr_step(rp);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wp[IDX_W-1:0] == IDX_W'(g))) slot[g] <= wr_data;
    end
  end

  assign occ   = fill_level(wp, rp);
  assign full  = (occ == PTR_W'(DEPTH));
  assign empty = (occ == '0);
  assign head  = slot[rp[IDX_W-1:0]];

endmodule

// File: rtl/rtr_link_ctrl.sv
module rtr_link_ctrl
  import rtr_flit_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic put_i,
  input  logic full,
  input  logic pop,
  output logic rdy_o,
  output logic wr_fire
);

  link_phase_e phase, phase_nx;
  logic        slot_free;

  // A pop at this edge frees a slot even if the store is full now.
  assign slot_free = !full || pop;
  assign wr_fire   = (phase == PH_OPEN) && put_i;
  assign rdy_o     = (phase == PH_OPEN);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_OPEN:  if (put_i) phase_nx = PH_HOLD;
      PH_HOLD:  if (!put_i) phase_nx = slot_free ? PH_OPEN : PH_STALL;
      PH_STALL: if (!put_i && slot_free) phase_nx = PH_OPEN;
      default:  phase_nx = PH_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_OPEN;
    else     phase <= phase_nx;
  end

endmodule

// File: rtl/rtr_flit_rx.sv
module rtr_flit_rx #(
  parameter int unsigned FLIT_W = rtr_flit_rx_pkg::FLIT_W_DEF,
  parameter int unsigned DEPTH  = rtr_flit_rx_pkg::DEPTH_DEF,
  localparam int unsigned OCC_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put_i,
  input  logic [FLIT_W-1:0] flit_i,
  output logic              rdy_o,
  input  logic              get_i,
  output logic              valid_o,
  output logic [FLIT_W-1:0] flit_o
);

  // Named internal events, also observed by the bound checker.
  logic             wr_fire;
  logic             rd_fire;
  logic             full;
  logic             empty;
  logic [OCC_W-1:0] occ;

  assign rd_fire = get_i && !empty;
  assign valid_o = !empty;

  rtr_link_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .put_i   (put_i),
    .full    (full),
    .pop     (rd_fire),
    .rdy_o   (rdy_o),
    .wr_fire (wr_fire)
  );

  rtr_flit_ring #(
    .FLIT_W (FLIT_W),
    .DEPTH  (DEPTH)
  ) u_ring (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_fire),
    .wr_data (flit_i),
    .rd_en   (rd_fire),
    .head    (flit_o),
    .full    (full),
    .empty   (empty),
    .occ     (occ)
  );

endmodule

// File: rtl/rtr_flit_rx_chk.sv
module rtr_flit_rx_chk #(
  parameter int unsigned OCC_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             put_i,
  input logic             get_i,
  input logic             rdy_o,
  input logic             valid_o,
  input logic             wr_fire,
  input logic             rd_fire,
  input logic             full,
  input logic [OCC_W-1:0] occ
);

  AST_WRITE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !rdy_o); // R2

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!rdy_o && put_i) |=> !rdy_o); // R3

  AST_RISE_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_o) |-> !$past(put_i)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    full |-> !rdy_o); // R5

  AST_EMPTY_GET: assert property (@(posedge clk) disable iff (rst)
    (get_i && !valid_o && !put_i) |=> !valid_o); // R7

  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && rd_fire) |=> $stable(occ)); // R8

endmodule

bind rtr_flit_rx rtr_flit_rx_chk #(.OCC_W(OCC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .put_i   (put_i),
  .get_i   (get_i),
  .rdy_o   (rdy_o),
  .valid_o (valid_o),
  .wr_fire (wr_fire),
  .rd_fire (rd_fire),
  .full    (full),
  .occ     (occ)
);

// File: tb/tb_rtr_flit_rx.sv
module tb_rtr_flit_rx;

  localparam int W = 34;

  logic         clk = 1'b0;
  logic         rst;
  logic         put_i;
  logic [W-1:0] flit_i;
  logic         rdy_o;
  logic         get_i;
  logic         valid_o;
  logic [W-1:0] flit_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rtr_flit_rx dut (
    .clk     (clk),
    .rst     (rst),
    .put_i   (put_i),
    .flit_i  (flit_i),
    .rdy_o   (rdy_o),
    .get_i   (get_i),
    .valid_o (valid_o),
    .flit_o  (flit_o)
  );

  typedef struct packed {
    logic         put;
    logic         get;
    logic [W-1:0] din;
    logic         e_rdy;
    logic         e_val;
    logic [W-1:0] e_flit;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b0, 34'h1_0000_00A1, 1'b0, 1'b1, 34'h1_0000_00A1}, // R2 capture
    '{1'b1, 1'b0, 34'h2_FFFF_0000, 1'b0, 1'b1, 34'h1_0000_00A1}, // R3 held put
    '{1'b0, 1'b0, 34'h0,           1'b1, 1'b1, 34'h1_0000_00A1}, // R4 reopen
    '{1'b1, 1'b1, 34'h0_0000_0B22, 1'b0, 1'b1, 34'h0_0000_0B22}, // R8 write+pop
    '{1'b0, 1'b0, 34'h0,           1'b1, 1'b1, 34'h0_0000_0B22}, // R4
    '{1'b0, 1'b1, 34'h0,           1'b1, 1'b0, 34'h0},           // R8 one pop empties
    '{1'b0, 1'b1, 34'h0,           1'b1, 1'b0, 34'h0},           // R7 empty get
    '{1'b1, 1'b0, 34'h3_0C0C_0C33, 1'b0, 1'b1, 34'h3_0C0C_0C33}, // R6
    '{1'b0, 1'b1, 34'h0,           1'b1, 1'b0, 34'h0}            // R4 pop on drop
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Full four-phase transfer; returns after put is withdrawn for one edge.
  task automatic send(input logic [W-1:0] d, input logic exp_rdy_after);
    while (!rdy_o) tick();
    put_i  = 1'b1;
    flit_i = d;
    tick();
    check("R2 flag low after capture", W'(rdy_o), W'(0));
    put_i = 1'b0;
    tick();
    check("R4/R5 flag after drop", W'(rdy_o), W'(exp_rdy_after));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; put_i = 1'b0; get_i = 1'b0; flit_i = '0;
    @(negedge clk);
    tick();
    rst = 1'b0;
    check("R1 rdy after reset", W'(rdy_o), W'(1));
    check("R1 valid after reset", W'(valid_o), W'(0));

    foreach (VECS[i]) begin
      put_i  = VECS[i].put;
      get_i  = VECS[i].get;
      flit_i = VECS[i].din;
      tick();
      check($sformatf("R2-table step %0d rdy", i), W'(rdy_o), W'(VECS[i].e_rdy));
      check($sformatf("R6 table step %0d valid", i), W'(valid_o), W'(VECS[i].e_val));
      if (VECS[i].e_val)
        check($sformatf("R6 table step %0d flit", i), flit_o, VECS[i].e_flit);
    end
    put_i = 1'b0; get_i = 1'b0;
    tick();

    // R9 / R5: fill all four slots, the link must stall.
    for (int k = 0; k < 4; k++) send(W'(34'h1_5500_0000 + k), k < 3);
    check("R5 stall holds", W'(rdy_o), W'(0));
    // Misbehaving sender keeps put high while full: nothing stored (R3).
    put_i = 1'b1; flit_i = 34'h3_DEAD_BEEF;
    tick();
    tick();
    check("R3 no capture while low", W'(rdy_o), W'(0));
    put_i = 1'b0;
    tick();
    check("R5 still stalled without get", W'(rdy_o), W'(0));
    check("R6 head is first", flit_o, 34'h1_5500_0000);
    get_i = 1'b1;
    tick();
    get_i = 1'b0;
    check("R5 reopen after one pop", W'(rdy_o), W'(1));
    for (int k = 1; k < 4; k++) begin
      check("R9 valid while draining", W'(valid_o), W'(1));
      check("R6 drain order", flit_o, W'(34'h1_5500_0000 + k));
      get_i = 1'b1;
      tick();
      get_i = 1'b0;
    end
    check("R9 empty after four", W'(valid_o), W'(0));
    get_i = 1'b1;
    tick();
    get_i = 1'b0;
    check("R7 empty get no effect", W'(valid_o), W'(0));
    send(34'h0_1234_5678, 1'b1);
    check("R7 later flit kept", flit_o, 34'h0_1234_5678);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule